// File: doc/BRIEF.md
# Sixteen-Operation Integer Lane ALU

This block is the execution unit of one lane in a lockstep multi-lane engine. A 4-bit opcode selects one of sixteen operations on two 32-bit operands and a 16-bit immediate. The immediate is zero-extended. The result, a zero flag and an error flag appear in the same cycle, with no internal state. Several copies can sit side by side, one per lane, all driven by a shared opcode.

The operations are wrap-around add and subtract, a multiply that keeps the low word, unsigned divide and remainder, and the plain and inverted bitwise functions. There are also logical shifts, an add-immediate and a move-immediate. A zero divisor never stalls the lane and never produces an undefined value. Divide and remainder then return all ones and raise the error flag, and any later logic in the lane can test that flag.

Top module: `lane_alu`

## Requirements
- R1: Opcode 0000 returns (A + B) mod 2^32 and opcode 0001 returns (A - B) mod 2^32.
- R2: Opcode 0010 returns the low 32 bits of the full unsigned product A × B.
- R3: The bitwise opcodes are 0100 (A & B), 0101 (A | B), 0110 (A ^ B), 1010 ~(A & B), 1011 ~(A | B) and 1100 ~(A ^ B). Opcode 0111 returns ~A, and the value of B has no effect on its result.
- R4: With a nonzero B, opcode 0011 returns the unsigned quotient A / B and opcode 1101 returns the unsigned remainder A % B.
- R5: When B is zero, opcodes 0011 and 1101 return 0xFFFFFFFF and raise the error flag.
- R6: The error flag is low for every opcode other than 0011 and 1101, and it is also low for those two opcodes when B is nonzero.
- R7: Opcode 1110 returns A plus the zero-extended immediate, mod 2^32. Opcode 1111 returns the zero-extended immediate, and neither A nor B has any effect on its result.
- R8: Opcode 1000 shifts A left and opcode 1001 shifts A right, both logically and with zero fill. The shift amount is B[4:0] only, and bits B[31:5] have no effect.
- R9: The zero flag is high exactly when the 32-bit result equals zero, for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation select |
| src_a | input | 32 | First operand, and the dividend |
| src_b | input | 32 | Second operand, the divisor or the shift amount |
| imm | input | 16 | Immediate, zero-extended inside the block |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is zero |
| err_flag | output | 1 | High on divide or remainder by zero |

## Verification
The bench builds the block at its default widths of a 32-bit datapath and a 16-bit immediate. At these widths the word boundaries are reachable with directed values: wrap-around on add, products above 2^32 (including one whose low word is zero), shift amounts whose upper bits are set, and both zero-divisor cases. A behavioural model that uses wide integers is then compared against the block for every opcode under several hundred random operand sets. Some of these sets force B to zero so that the divide guard is exercised repeatedly.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOT  = 4'h7,
    OP_SHL  = 4'h8,
    OP_SHR  = 4'h9,
    OP_NAND = 4'hA,
    OP_NOR  = 4'hB,
    OP_XNOR = 4'hC,
    OP_MOD  = 4'hD,
    OP_ADDI = 4'hE,
    OP_MOV  = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_ARITH = 2'd0,
    SEL_QUOT  = 2'd1,
    SEL_REM   = 2'd2,
    SEL_LOGIC = 2'd3
  } res_sel_e;

endpackage

// File: rtl/lane_alu_arith.sv
module lane_alu_arith
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm_x,
  output logic [DATA_W-1:0] arith_res
);

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod_full;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sum_res;

  always_comb begin
    prod_full = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
  end

  always_comb begin
    addend  = (op == OP_ADDI) ? imm_x : b;
    sum_res = a + addend;
  end

  always_comb begin
    unique case (op)
      OP_SUB:  arith_res = a - b;
      OP_MUL:  arith_res = prod_full[DATA_W-1:0];
      default: arith_res = sum_res;
    endcase
  end

endmodule

// File: rtl/lane_alu_divmod.sv
module lane_alu_divmod #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] quot,
  output logic [DATA_W-1:0] rem,
  output logic              div_zero
);

  localparam int CHK_W = 2 * DATA_W;

  always_comb begin
    div_zero = (divisor == '0);
    if (div_zero) begin
      quot = '1;
      rem  = '1;
    end else begin
      quot = dividend / divisor;
      rem  = dividend % divisor;
    end
  end

  logic [CHK_W-1:0] recon;
  always_comb begin
    recon = {{DATA_W{1'b0}}, quot} * {{DATA_W{1'b0}}, divisor}
          + {{DATA_W{1'b0}}, rem};
    if (!div_zero) begin
      AST_DIV_RECON: assert (recon == {{DATA_W{1'b0}}, dividend} && rem < divisor)
        else $error("quotient/remainder do not rebuild dividend"); // R4
    end
  end

endmodule

// File: rtl/lane_alu_logic.sv
module lane_alu_logic
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm_x,
  output logic [DATA_W-1:0] logic_res
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   sh_amt;
  logic [DATA_W-1:0] and_v, or_v, xor_v;

  always_comb begin
    sh_amt = b[SH_W-1:0];
    and_v  = a & b;
    or_v   = a | b;
    xor_v  = a ^ b;
  end

  always_comb begin
    unique case (op)
      OP_AND:  logic_res = and_v;
      OP_OR:   logic_res = or_v;
      OP_XOR:  logic_res = xor_v;
      OP_NAND: logic_res = ~and_v;
      OP_NOR:  logic_res = ~or_v;
      OP_XNOR: logic_res = ~xor_v;
      OP_NOT:  logic_res = ~a;
      OP_SHL:  logic_res = a << sh_amt;
      OP_SHR:  logic_res = a >> sh_amt;
      OP_MOV:  logic_res = imm_x;
      default: logic_res = '0;
    endcase
  end

  always_comb begin
    if (op == OP_SHR && sh_amt != '0) begin
      AST_SHR_FILL: assert (logic_res[DATA_W-1] == 1'b0)
        else $error("logical right shift did not fill with zero"); // R8
    end
    if (op == OP_SHL && sh_amt != '0) begin
      AST_SHL_FILL: assert (logic_res[0] == 1'b0)
        else $error("left shift did not fill with zero"); // R8
    end
  end

endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              zero_flag,
  output logic              err_flag
);

  localparam int PAD_W = DATA_W - IMM_W;

  alu_op_e           op;
  res_sel_e          sel;
  logic [DATA_W-1:0] imm_x;
  logic [DATA_W-1:0] arith_res, logic_res, quot, rem;
  logic              div_zero;
  logic              is_divmod;

  always_comb begin
    op    = alu_op_e'(opcode);
    imm_x = {{PAD_W{1'b0}}, imm};
  end

  lane_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op        (op),
    .a         (src_a),
    .b         (src_b),
    .imm_x     (imm_x),
    .arith_res (arith_res)
  );

  lane_alu_divmod #(.DATA_W(DATA_W)) u_divmod (
    .dividend (src_a),
    .divisor  (src_b),
    .quot     (quot),
    .rem      (rem),
    .div_zero (div_zero)
  );

  lane_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op        (op),
    .a         (src_a),
    .b         (src_b),
    .imm_x     (imm_x),
    .logic_res (logic_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_ADDI: sel = SEL_ARITH;
      OP_DIV:                          sel = SEL_QUOT;
      OP_MOD:                          sel = SEL_REM;
      default:                         sel = SEL_LOGIC;
    endcase
  end

  always_comb begin
    unique case (sel)
      SEL_ARITH: result = arith_res;
      SEL_QUOT:  result = quot;
      SEL_REM:   result = rem;
      default:   result = logic_res;
    endcase
    is_divmod = (sel == SEL_QUOT) || (sel == SEL_REM);
    err_flag  = is_divmod & div_zero;
    zero_flag = (result == '0);
  end

  always_comb begin
    if ((op == OP_DIV || op == OP_MOD) && src_b == '0) begin
      AST_DIVZERO_ONES: assert (&result && err_flag)
        else $error("zero divisor did not give all ones with error"); // R5
    end
    if (err_flag) begin
      AST_ERR_ONLY_DIVZERO: assert ((op == OP_DIV || op == OP_MOD) && src_b == '0)
        else $error("error flag raised outside divide by zero"); // R6
    end
    if (op == OP_MOV) begin
      AST_MOV_PASS: assert (result == imm_x)
        else $error("move did not return the immediate"); // R7
    end
    if (op == OP_NOT) begin
      AST_NOT_INVERT: assert ((result ^ src_a) == '1)
        else $error("complement mismatch"); // R3
    end
  end

endmodule

// File: tb/lane_alu_bench.sv
module lane_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic [3:0]  opcode;
  logic [31:0] src_a, src_b;
  logic [15:0] imm;
  logic [31:0] result;
  logic        zero_flag, err_flag;

  int n_tests;
  int n_fail;
  bit done;

  lane_alu u_lane_alu (
    .opcode    (opcode),
    .src_a     (src_a),
    .src_b     (src_b),
    .imm       (imm),
    .result    (result),
    .zero_flag (zero_flag),
    .err_flag  (err_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_res(input logic [3:0] op,
                                            input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [15:0] im);
    longint unsigned la, lb, li;
    la = longint'(a);
    lb = longint'(b);
    li = longint'(im);
    case (op)
      4'h0: return 32'((la + lb) % 64'h1_0000_0000);
      4'h1: return 32'((la - lb) & 64'hFFFF_FFFF);
      4'h2: return 32'((la * lb) & 64'hFFFF_FFFF);
      4'h3: return (lb == 0) ? 32'hFFFF_FFFF : 32'(la / lb);
      4'h4: return a & b;
      4'h5: return a | b;
      4'h6: return a ^ b;
      4'h7: return ~a;
      4'h8: return 32'((la * (64'd1 << (lb % 32))) & 64'hFFFF_FFFF);
      4'h9: return 32'(la / (64'd1 << (lb % 32)));
      4'hA: return ~(a & b);
      4'hB: return ~(a | b);
      4'hC: return ~(a ^ b);
      4'hD: return (lb == 0) ? 32'hFFFF_FFFF : 32'(la % lb);
      4'hE: return 32'((la + li) % 64'h1_0000_0000);
      default: return 32'(li);
    endcase
  endfunction

  task automatic check_val(input string req, input string what,
                           input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im,
                       input string req);
    logic [31:0] exp_r;
    @(negedge clk);
    opcode = op; src_a = a; src_b = b; imm = im;
    #(CLK_PERIOD/4);
    exp_r = model_res(op, a, b, im);
    check_val(req, "result", result, exp_r);
    check_val("R9", "zero_flag", {31'b0, zero_flag}, {31'b0, exp_r == 32'h0});
    check_val((op == 4'h3 || op == 4'hD) ? "R5" : "R6", "err_flag",
              {31'b0, err_flag},
              {31'b0, (op == 4'h3 || op == 4'hD) && b == 32'h0});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    opcode = 4'h0; src_a = '0; src_b = '0; imm = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // initial state: ADD of zeros gives zero result and zero flag
    apply(4'h0, 32'h0, 32'h0, 16'h0, "R9");
    // R1 add/sub with wrap
    apply(4'h0, 32'd10, 32'd20, 16'h0, "R1");
    apply(4'h0, 32'hFFFF_FFFF, 32'h1, 16'h0, "R1");
    apply(4'h1, 32'd5, 32'd7, 16'h0, "R1");
    apply(4'h1, 32'd9, 32'd9, 16'h0, "R1");
    // R2 multiply, large products
    apply(4'h2, 32'd30, 32'd5, 16'h0, "R2");
    apply(4'h2, 32'h0001_0000, 32'h0001_0000, 16'h0, "R2");
    apply(4'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, "R2");
    apply(4'h2, 32'h1234_5678, 32'h9ABC_DEF0, 16'h0, "R2");
    // R3 bitwise
    apply(4'h4, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, "R3");
    apply(4'h5, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, "R3");
    apply(4'h6, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, "R3");
    apply(4'hA, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, "R3");
    apply(4'hB, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, "R3");
    apply(4'hC, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, "R3");
    apply(4'h7, 32'hA5A5_0000, 32'h0, 16'h0, "R3");
    apply(4'h7, 32'hA5A5_0000, 32'hDEAD_BEEF, 16'h0, "R3");
    apply(4'h7, 32'hFFFF_FFFF, 32'h1234_0000, 16'h0, "R3");
    // R4 unsigned divide/remainder
    apply(4'h3, 32'd100, 32'd7, 16'h0, "R4");
    apply(4'hD, 32'd100, 32'd7, 16'h0, "R4");
    apply(4'h3, 32'hFFFF_FFFE, 32'd2, 16'h0, "R4");
    apply(4'hD, 32'h8000_0001, 32'hFFFF_FFFF, 16'h0, "R4");
    apply(4'h3, 32'd3, 32'd9, 16'h0, "R4");
    // R5 divide by zero
    apply(4'h3, 32'd123, 32'd0, 16'h0, "R5");
    apply(4'hD, 32'd123, 32'd0, 16'h0, "R5");
    apply(4'h3, 32'd0, 32'd0, 16'h0, "R5");
    // R6 no error with zero B on other ops
    apply(4'h0, 32'd4, 32'd0, 16'h0, "R6");
    apply(4'h2, 32'd4, 32'd0, 16'h0, "R6");
    // R7 immediate ops
    apply(4'hE, 32'd10, 32'd99, 16'h0014, "R7");
    apply(4'hE, 32'hFFFF_FFF0, 32'd0, 16'hFFFF, "R7");
    apply(4'hF, 32'hDEAD_BEEF, 32'hCAFE_F00D, 16'h8001, "R7");
    apply(4'hF, 32'h1111_1111, 32'h2222_2222, 16'h0000, "R7");
    // R8 shifts
    apply(4'h8, 32'h0000_0001, 32'd31, 16'h0, "R8");
    apply(4'h8, 32'h0000_0003, 32'hFFFF_FFE5, 16'h0, "R8");
    apply(4'h9, 32'h8000_0000, 32'd31, 16'h0, "R8");
    apply(4'h9, 32'hF000_000F, 32'h0000_0024, 16'h0, "R8");
    apply(4'h9, 32'h8765_4321, 32'h0000_0020, 16'h0, "R8");
    // random sweep over every opcode
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 5 == 0) rb = 32'h0;
      apply(4'(i % 16), ra, rb, 16'($urandom), "R1-sweep R9");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule